// File: doc/BRIEF.md
# Segmented Page Table Translation Unit

This block maps a 32-bit virtual address to a physical address through a page table held in an on-chip entry memory. Pages are 4 KB. The low 12 address bits are the byte offset inside the page and reach the physical address unchanged. The bits above them name the page. Each table entry carries a valid flag and a 20-bit physical frame number. A present page yields the frame joined with the offset. An absent page yields a page-fault response with no translation.

The unit has two addressing modes, chosen by a static mode input. In flat mode the whole 20-bit page number is bounded by the first length register, and its low 10 bits index the table. In segmented mode bits 21:20 pick one of four segments, and bits 19:12 pick a page inside that segment. Each segment owns a quarter of the entry memory and has its own length register. Bits 31:22 are ignored in segmented mode.

A page number at or above the bounding length is refused before the table is touched. A configuration port writes table entries and length registers. Requests use a valid/ready handshake. The response appears one cycle after acceptance, and only one request is outstanding at a time.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset reqReady is 1 and rspValid is 0. Every entry is invalid and every length register is 0, so any request answers with fault cause 2'b01.
- R2: A request accepted on an edge (reqValid and reqReady both 1) gives rspValid = 1 for exactly the following cycle. reqReady is 0 during that cycle and returns to 1 after it.
- R3: On every response, rspPaddr[11:0] equals reqVaddr[11:0] of the accepted request when it translates, and rspPaddr is 0 when it faults.
- R4: Flat mode (segMode = 0): the page number is reqVaddr[31:12], it is bounded by length register 0, and table index reqVaddr[21:12] is used.
- R5: Segmented mode (segMode = 1): the segment is reqVaddr[21:20], the page is reqVaddr[19:12], the table index is segment*256 + page, and the length register of that segment bounds the page. reqVaddr[31:22] has no effect on the response.
- R6: A page number at or above its bounding length gives rspFault = 1, rspCause = 2'b01 and rspPaddr = 0.
- R7: An in-range page whose entry has a valid flag of 0 gives rspFault = 1, rspCause = 2'b10 and rspPaddr = 0.
- R8: An in-range page with a valid entry gives rspFault = 0, rspCause = 2'b00 and rspPaddr = {frame, reqVaddr[11:0]}.
- R9: Configuration write, taken on an edge with cfgWrite = 1. With cfgLen = 0, entry cfgIndex is written with valid = cfgData[31] and frame = cfgData[19:0]. With cfgLen = 1, length register cfgIndex[1:0] takes cfgData[10:0]. A request accepted on the same edge sees the old contents. A request accepted on a later edge sees the new contents.
- R10: The length check has priority. An out-of-range page answers with cause 2'b01 even when the entry it would index is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segMode | input | 1 | 1 selects segmented addressing, 0 selects flat |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can accept a request |
| reqVaddr | input | 32 | Virtual address of the request |
| rspValid | output | 1 | Response present this cycle |
| rspPaddr | output | 32 | Physical address, 0 on a fault |
| rspFault | output | 1 | Response is a fault |
| rspCause | output | 2 | 01 length violation, 10 invalid entry, 00 success |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgLen | input | 1 | 1 writes a length register, 0 writes a table entry |
| cfgIndex | input | 10 | Entry index, or segment number in bits 1:0 |
| cfgData | input | 32 | Entry word (bit 31 valid, bits 19:0 frame) or length in bits 10:0 |

## Verification
The assertions check the handshake rhythm on every cycle: one response exactly one cycle after each acceptance, and no acceptance while a response is shown. They also check that a response carries the accepted offset and that the fault flag agrees with a legal cause code. The mapping itself can only be shown by the bench's sweeps. Those sweeps cover the frame returned for each index, bounds per segment in both modes, priority of the length check over a valid entry, and that high address bits are ignored in segmented mode. The write-versus-lookup ordering on a shared edge is likewise shown only by a directed scenario.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int SEG_W   = 2;
  localparam int SPAGE_W = 8;
  localparam int FRAME_W = 20;
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int IDX_W   = SEG_W + SPAGE_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int NSEG    = 1 << SEG_W;
  localparam int LEN_W   = IDX_W + 1;
  localparam int VALID_BIT = 31;

  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_LEN  = 2'b01;
  localparam logic [1:0] CAUSE_INV  = 2'b10;

  typedef struct packed {
    logic             capture;
    logic             lookup;
    logic             lenFault;
    logic [IDX_W-1:0] index;
  } xlate_strobe_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                segMode,
  input  logic                reqValid,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic [LEN_W-1:0]    segLen,
  output logic [SEG_W-1:0]    segSel,
  output logic                reqReady,
  output logic                rspValid,
  output xlate_strobe_t       strobe
);
  logic pending;
  logic accept;
  logic inRange;
  logic [VPN_W-1:0]   flatVpn;
  logic [SPAGE_W-1:0] segPage;

  assign flatVpn  = reqVaddr[VA_W-1:OFF_W];
  assign segPage  = reqVaddr[OFF_W+SPAGE_W-1:OFF_W];
  assign segSel   = segMode ? reqVaddr[OFF_W+IDX_W-1:OFF_W+SPAGE_W] : '0;
  assign reqReady = !pending;
  assign rspValid = pending;
  assign accept   = reqValid && !pending;

  always_comb begin
    if (segMode) inRange = {{(LEN_W-SPAGE_W){1'b0}}, segPage} < segLen;
    else         inRange = flatVpn < {{(VPN_W-LEN_W){1'b0}}, segLen};
  end

  always_comb begin
    strobe.capture  = accept;
    strobe.lookup   = accept && inRange;
    strobe.lenFault = accept && !inRange;
    strobe.index    = reqVaddr[OFF_W+IDX_W-1:OFF_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= accept;
  end
endmodule

// File: rtl/xlate_dpath.sv
module xlate_dpath
  import xlate_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  xlate_strobe_t       strobe,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic [SEG_W-1:0]    segSel,
  output logic [LEN_W-1:0]    segLen,
  input  logic                cfgWrite,
  input  logic                cfgLen,
  input  logic [IDX_W-1:0]    cfgIndex,
  input  logic [VA_W-1:0]     cfgData,
  output logic [VA_W-1:0]     rspPaddr,
  output logic                rspFault,
  output logic [1:0]          rspCause
);
  logic [FRAME_W-1:0] frameMem [ENTRIES];
  logic [ENTRIES-1:0] validBits;
  logic [LEN_W-1:0]   lenRegs [NSEG];
  logic [FRAME_W-1:0] rdFrame;
  logic               rdValid;
  logic               lenFaultQ;
  logic [OFF_W-1:0]   offsetQ;

  assign segLen = lenRegs[segSel];

  always_ff @(posedge clk) begin
    if (cfgWrite && !cfgLen) frameMem[cfgIndex] <= cfgData[FRAME_W-1:0];
    if (strobe.lookup) rdFrame <= frameMem[strobe.index];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      rdValid   <= 1'b0;
      lenFaultQ <= 1'b0;
      offsetQ   <= '0;
    end else begin
      if (cfgWrite && !cfgLen) validBits[cfgIndex] <= cfgData[VALID_BIT];
      if (strobe.lookup) rdValid <= validBits[strobe.index];
      if (strobe.capture) begin
        lenFaultQ <= strobe.lenFault;
        offsetQ   <= reqVaddr[OFF_W-1:0];
      end
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_len
    always_ff @(posedge clk) begin
      if (!rstN) lenRegs[s] <= '0;
      else if (cfgWrite && cfgLen && (cfgIndex[SEG_W-1:0] == SEG_W'(s)))
        lenRegs[s] <= cfgData[LEN_W-1:0];
    end
  end

  always_comb begin
    if (lenFaultQ) begin
      rspFault = 1'b1;
      rspCause = CAUSE_LEN;
      rspPaddr = '0;
    end else if (!rdValid) begin
      rspFault = 1'b1;
      rspCause = CAUSE_INV;
      rspPaddr = '0;
    end else begin
      rspFault = 1'b0;
      rspCause = CAUSE_NONE;
      rspPaddr = {rdFrame, offsetQ};
    end
  end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              segMode,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  output logic              rspValid,
  output logic [VA_W-1:0]   rspPaddr,
  output logic              rspFault,
  output logic [1:0]        rspCause,
  input  logic              cfgWrite,
  input  logic              cfgLen,
  input  logic [IDX_W-1:0]  cfgIndex,
  input  logic [VA_W-1:0]   cfgData
);
  xlate_strobe_t    strobe;
  logic [LEN_W-1:0] segLen;
  logic [SEG_W-1:0] segSel;

  xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .segMode(segMode), .reqValid(reqValid),
    .reqVaddr(reqVaddr), .segLen(segLen), .segSel(segSel),
    .reqReady(reqReady), .rspValid(rspValid), .strobe(strobe)
  );

  xlate_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr),
    .segSel(segSel), .segLen(segLen), .cfgWrite(cfgWrite), .cfgLen(cfgLen),
    .cfgIndex(cfgIndex), .cfgData(cfgData), .rspPaddr(rspPaddr),
    .rspFault(rspFault), .rspCause(rspCause)
  );
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker
  import xlate_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [VA_W-1:0] reqVaddr,
  input logic            rspValid,
  input logic [VA_W-1:0] rspPaddr,
  input logic            rspFault,
  input logic [1:0]      rspCause
);
  // R2: accepted request answers in the next cycle
  a_r2_resp_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  // R2: no acceptance while a response is shown
  a_r2_single_flight: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  // R2: response lasts one cycle only
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R3: offset passes through on success
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (rspPaddr[OFF_W-1:0] == $past(reqVaddr[OFF_W-1:0])));

  // R3: fault carries no address
  a_r3_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspPaddr == '0));

  // R6 / R7 / R8: fault flag agrees with a legal cause
  a_r8_cause_legal: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((rspCause != 2'b11) && (rspFault == (rspCause != CAUSE_NONE))));
endmodule

bind page_xlate_unit xlate_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqVaddr(reqVaddr), .rspValid(rspValid), .rspPaddr(rspPaddr),
  .rspFault(rspFault), .rspCause(rspCause)
);

// File: tb/sim_page_xlate_unit.sv
module sim_page_xlate_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segMode = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic        rspFault;
  logic [1:0]  rspCause;
  logic        cfgWrite = 1'b0;
  logic        cfgLen = 1'b0;
  logic [9:0]  cfgIndex = '0;
  logic [31:0] cfgData = '0;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic        bValid [1024];
  logic [19:0] bFrame [1024];
  logic [10:0] bLen [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate_unit u0 (
    .clk(clk), .rstN(rstN), .segMode(segMode), .reqValid(reqValid),
    .reqReady(reqReady), .reqVaddr(reqVaddr), .rspValid(rspValid),
    .rspPaddr(rspPaddr), .rspFault(rspFault), .rspCause(rspCause),
    .cfgWrite(cfgWrite), .cfgLen(cfgLen), .cfgIndex(cfgIndex), .cfgData(cfgData)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [34:0] expect_rsp(input logic mode, input logic [31:0] va);
    logic [9:0]  idx;
    logic [1:0]  seg;
    logic        inr;
    seg = mode ? va[21:20] : 2'd0;
    idx = va[21:12];
    if (mode) inr = {3'b0, va[19:12]} < bLen[seg];
    else      inr = va[31:12] < {9'b0, bLen[0]};
    if (!inr)              return {1'b1, 2'b01, 32'h0};
    else if (!bValid[idx]) return {1'b1, 2'b10, 32'h0};
    else                   return {1'b0, 2'b00, bFrame[idx], va[11:0]};
  endfunction

  task automatic cfg_entry(input int idx, input logic v, input logic [19:0] fr);
    @(negedge clk);
    cfgWrite = 1'b1; cfgLen = 1'b0; cfgIndex = 10'(idx);
    cfgData = {v, 11'h7FF, fr};
    @(posedge clk);
    @(negedge clk);
    cfgWrite = 1'b0;
    bValid[idx] = v; bFrame[idx] = fr;
  endtask

  task automatic cfg_len(input int seg, input logic [10:0] len);
    @(negedge clk);
    cfgWrite = 1'b1; cfgLen = 1'b1; cfgIndex = 10'(seg);
    cfgData = {21'h1FFFFF, len};
    @(posedge clk);
    @(negedge clk);
    cfgWrite = 1'b0;
    bLen[seg] = len;
  endtask

  task automatic xlate(input string tag, input logic [31:0] va, input logic [34:0] exp);
    @(negedge clk);
    check({tag, " R2 ready before request"}, 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqVaddr = va;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqVaddr = ~va;
    check({tag, " R2 rspValid"}, 64'(rspValid), 64'd1);
    check({tag, " R2 ready low"}, 64'(reqReady), 64'd0);
    check(tag, 64'({rspFault, rspCause, rspPaddr}), 64'(exp));
    @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin bValid[i] = 1'b0; bFrame[i] = '0; end
    for (int s = 0; s < 4; s++) bLen[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 ready after reset", 64'(reqReady), 64'd1);
    check("R1 no response after reset", 64'(rspValid), 64'd0);
    xlate("R1 flat zero length", 32'h0000_0123, {1'b1, 2'b01, 32'h0});
    segMode = 1'b1;
    xlate("R1 seg zero length", 32'h0030_0456, {1'b1, 2'b01, 32'h0});
    for (int s = 0; s < 4; s++) cfg_len(s, 11'd256);
    xlate("R1 entry invalid after reset", 32'h0012_3004, {1'b1, 2'b10, 32'h0});

    for (int i = 0; i < 1024; i++)
      cfg_entry(i, ((i * 7) % 5) != 0, 20'((i * 20'h1F3 + 20'h0A5C3) & 20'hFFFFF));

    segMode = 1'b0;
    cfg_len(0, 11'd700);
    for (int v = 0; v < 1024; v++) begin
      logic [31:0] va;
      va = {20'(v), 12'((v * 113) & 12'hFFF)};
      xlate("R4 R6 R7 R8 flat sweep", va, expect_rsp(1'b0, va));
    end
    xlate("R4 R10 flat high vpn", 32'h0400_5ABC, {1'b1, 2'b01, 32'h0});
    xlate("R4 R8 flat last in range", {20'd699, 12'hFFF}, expect_rsp(1'b0, {20'd699, 12'hFFF}));

    segMode = 1'b1;
    cfg_len(0, 11'd180);
    cfg_len(1, 11'd256);
    cfg_len(2, 11'd0);
    cfg_len(3, 11'd97);
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] va;
      va = {10'((i * 3) & 10'h3FF), 10'(i), 12'((i * 59) & 12'hFFF)};
      xlate("R5 R6 R7 R8 seg sweep", va, expect_rsp(1'b1, va));
    end
    xlate("R5 high bits ignored", 32'hFFC0_1ABC, expect_rsp(1'b1, 32'h0000_1ABC));
    xlate("R10 seg out of range valid entry", {10'h0, 2'd0, 8'd181, 12'h010}, {1'b1, 2'b01, 32'h0});

    segMode = 1'b0;
    cfg_len(0, 11'd1024);
    cfg_entry(5, 1'b1, 20'hABCDE);
    @(negedge clk);
    cfgWrite = 1'b1; cfgLen = 1'b0; cfgIndex = 10'd5; cfgData = {1'b1, 11'h0, 20'h12345};
    reqValid = 1'b1; reqVaddr = 32'h0000_5321;
    @(posedge clk);
    @(negedge clk);
    cfgWrite = 1'b0; reqValid = 1'b0;
    bFrame[5] = 20'h12345;
    check("R9 same-edge write not seen", 64'({rspFault, rspCause, rspPaddr}),
          64'({1'b0, 2'b00, 20'hABCDE, 12'h321}));
    @(posedge clk);
    xlate("R9 later request sees write", 32'h0000_5321, {1'b0, 2'b00, 20'h12345, 12'h321});
    cfg_entry(5, 1'b0, 20'h12345);
    xlate("R9 R7 cleared valid faults", 32'h0000_5321, {1'b1, 2'b10, 32'h0});

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule